// File: doc/BRIEF.md
# Supply-Aware Isolation Gate with Software Enables

This block stands on the boundary between a controlling domain (a processor and its peripherals) and a user logic region whose core supply can be switched off. Signals leaving the controlling side toward the user region are forced to 0, and their output-enable is dropped, whenever the user-1 core supply is not reported good. A user region that is unpowered therefore receives no driven level from the controlling side.

Signals returning from the user region are qualified bit by bit. The 128 logic-analyzer lines, the three interrupt lines, and the returned bus data and acknowledge each pass through an AND with an enable bit. Only the controlling processor can set these enables, and all of them clear on reset. Unconnected or floating user outputs are therefore harmless until software enables them.

The enables and a read-only view of four supply power-good flags sit in a small register bank. The processor reaches the bank over a valid/ready memory-mapped port that has a fixed one-cycle read latency.

Top module: `pwr_iso_gate`

## Requirements
- R1: While `pg_raw[3]` (user-1 core supply good) is 0, `usr_out` is all zeros and `usr_oe` is 0. While it is 1, `usr_out` equals `ctl_out` and `usr_oe` is 1. The other `pg_raw` bits have no effect on this.
- R2: Each bit `la_to_ctl[i]` equals `la_from_usr[i]` AND the logic-analyzer enable bit `i`.
- R3: The logic-analyzer enables are four 32-bit read/write words at byte offsets 0x20, 0x24, 0x28 and 0x2C. The word at 0x20+4k holds enable bits 32k+31 down to 32k.
- R4: The interrupt-enable register at offset 0x04 keeps write-data bits 2:0 and reads back with bits 31:3 as 0. `irq_to_ctl[j]` equals `irq_from_usr[j]` AND enable bit j.
- R5: The bus-enable register at offset 0x08 keeps write-data bit 0. While that bit is 0, `ctl_bus_dat` is 0 and `ctl_bus_ack` is 0. While it is 1, both follow the user-side values.
- R6: The status register at offset 0x00 reads the `pg_raw` flags in bits 3:0, after a two-flop synchronizer, with bits 31:4 as 0. Bit order: 0 user-2 analog, 1 user-1 analog, 2 user-2 core, 3 user-1 core.
- R7: A write to offset 0x00 changes no register.
- R8: After reset every enable is 0, so all of `la_to_ctl`, `irq_to_ctl`, `ctl_bus_dat` and `ctl_bus_ack` are 0 for any user-side input.
- R9: A misaligned address, or any address other than 0x00, 0x04, 0x08 and 0x20–0x2C, reads as 0, and a write to it changes no register.
- R10: `req_ready` is always 1. Each cycle with `req_valid` high is one access, and `rsp_valid` is high in the following cycle only. For a read, `rsp_rdata` in that cycle carries the addressed value. For a write, it carries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| pg_raw | input | 4 | Supply power-good flags (asynchronous levels) |
| ctl_out | input | 32 | Controlling-side signals headed to the user region |
| usr_out | output | 32 | Clamped signals to the user region |
| usr_oe | output | 1 | Output-enable for `usr_out` (0 means high impedance) |
| la_from_usr | input | 128 | Logic-analyzer lines from the user region |
| la_to_ctl | output | 128 | Masked logic-analyzer lines |
| irq_from_usr | input | 3 | User interrupt lines |
| irq_to_ctl | output | 3 | Masked interrupt lines |
| usr_bus_dat | input | 32 | Bus read data returned by the user region |
| usr_bus_ack | input | 1 | Bus acknowledge returned by the user region |
| ctl_bus_dat | output | 32 | Gated bus read data |
| ctl_bus_ack | output | 1 | Gated bus acknowledge |

## Verification
Two functions can land in the same cycle: a register write that changes an enable, and the masking of live user-side data on the bits that enable controls. The bench holds the logic-analyzer and interrupt inputs at all ones while the enabling write is accepted. It checks that the masked output still shows the old enable before the clock edge and shows the new one right after it. A second overlap comes from the status path: a write to the status offset is accepted while the power-good inputs hold a new value. The test then confirms that the readback shows the synchronized inputs and that no enable moved.

// File: rtl/pwr_iso_pkg.sv
// Shared constants and types for the supply-aware isolation gate.
// Assumes a 32-bit data path and byte addressing with word-aligned registers.
package pwr_iso_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int PG_W   = 4;
    localparam int IRQ_W  = 3;

    // Index of the user-1 core supply flag in the power-good vector.
    localparam int PG_CORE_USR1 = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_BUS_EN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_LA_BASE = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_IRQ,
        SEL_BUS,
        SEL_LA
    } reg_sel_e;
endpackage

// File: rtl/pwr_iso_sync.sv
// Two-flop synchronizer for asynchronous level inputs.
// Assumes inputs are slow levels; bits are synchronized independently.
module pwr_iso_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Purpose: capture the asynchronous levels, then resample them once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/pwr_iso_regs.sv
// Register bank: power-good status (read-only), interrupt enable, bus enable,
// and logic-analyzer input-enable words behind a valid/ready access port.
// Assumes one access per cycle with valid high; ready is always granted.
module pwr_iso_regs
    import pwr_iso_pkg::*;
#(
    parameter int LA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [PG_W-1:0]   pg_sync,
    output logic [LA_W-1:0]   la_en,
    output logic [IRQ_W-1:0]  irq_en,
    output logic              bus_en
);
    localparam int LA_WORDS = LA_W / DATA_W;
    localparam int IDX_W    = (LA_WORDS > 1) ? $clog2(LA_WORDS) : 1;
    localparam logic [ADDR_W-1:0] LA_SPAN = ADDR_W'(LA_WORDS * 4);

    logic [LA_WORDS-1:0][DATA_W-1:0] la_words;
    logic [ADDR_W-1:0]               la_off;
    logic [IDX_W-1:0]                la_idx;
    reg_sel_e                        sel;
    logic [DATA_W-1:0]               rd_val;
    logic                            wr_fire;

    assign la_en   = la_words;
    assign wr_fire = req_valid && req_write;

    // Purpose: decode the byte address into a register select and word index.
    always_comb begin
        sel    = SEL_NONE;
        la_off = req_addr - OFS_LA_BASE;
        la_idx = la_off[IDX_W+1:2];
        if (req_addr[1:0] == 2'b00) begin
            if (req_addr == OFS_STATUS)      sel = SEL_STATUS;
            else if (req_addr == OFS_IRQ_EN) sel = SEL_IRQ;
            else if (req_addr == OFS_BUS_EN) sel = SEL_BUS;
            else if (req_addr >= OFS_LA_BASE && la_off < LA_SPAN) sel = SEL_LA;
        end
    end

    // Purpose: update the writable enables; status and unmapped writes drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_words <= '0;
            irq_en   <= '0;
            bus_en   <= 1'b0;
        end else if (wr_fire) begin
            case (sel)
                SEL_IRQ: irq_en           <= req_wdata[IRQ_W-1:0];
                SEL_BUS: bus_en           <= req_wdata[0];
                SEL_LA:  la_words[la_idx] <= req_wdata;
                default: ;
            endcase
        end
    end

    // Purpose: select the read value for the addressed register.
    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_STATUS: rd_val[PG_W-1:0]  = pg_sync;
            SEL_IRQ:    rd_val[IRQ_W-1:0] = irq_en;
            SEL_BUS:    rd_val[0]         = bus_en;
            SEL_LA:     rd_val            = la_words[la_idx];
            default:    rd_val            = '0;
        endcase
    end

    // Purpose: register the response one cycle after the access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
        end
    end

    // R10: every accepted access yields exactly one response in the next cycle.
    p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7: a status write leaves every enable untouched.
    p_status_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && sel == SEL_STATUS) |=>
        ($stable(la_words) && $stable(irq_en) && $stable(bus_en)));

    // R9: unmapped writes are dropped and unmapped reads return zero.
    p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && sel == SEL_NONE) |=>
        ($stable(la_words) && $stable(irq_en) && $stable(bus_en)));
    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel == SEL_NONE) |=> (rsp_rdata == '0));
endmodule

// File: rtl/pwr_iso_mask.sv
// Gating fabric: clamps outward signals on the core supply flag and ANDs
// every inbound user signal with its enable bit.
// Assumes the supply flag is a clean level; clamping is combinational.
module pwr_iso_mask
    import pwr_iso_pkg::*;
#(
    parameter int LA_W  = 128,
    parameter int OUT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_good,
    input  logic [OUT_W-1:0]  ctl_out,
    output logic [OUT_W-1:0]  usr_out,
    output logic              usr_oe,
    input  logic [LA_W-1:0]   la_en,
    input  logic [LA_W-1:0]   la_from_usr,
    output logic [LA_W-1:0]   la_to_ctl,
    input  logic [IRQ_W-1:0]  irq_en,
    input  logic [IRQ_W-1:0]  irq_from_usr,
    output logic [IRQ_W-1:0]  irq_to_ctl,
    input  logic              bus_en,
    input  logic [DATA_W-1:0] usr_bus_dat,
    input  logic              usr_bus_ack,
    output logic [DATA_W-1:0] ctl_bus_dat,
    output logic              ctl_bus_ack
);
    // Purpose: hold outward signals low and undriven while the core supply is down.
    assign usr_oe  = core_good;
    assign usr_out = ctl_out & {OUT_W{core_good}};

    // Purpose: per-bit qualification of the logic-analyzer lines.
    for (genvar i = 0; i < LA_W; i++) begin : g_la
        assign la_to_ctl[i] = la_from_usr[i] & la_en[i];
    end

    // Purpose: per-line qualification of the user interrupts.
    for (genvar j = 0; j < IRQ_W; j++) begin : g_irq
        assign irq_to_ctl[j] = irq_from_usr[j] & irq_en[j];
    end

    // Purpose: gate the returned bus data and acknowledge with one enable.
    assign ctl_bus_dat = usr_bus_dat & {DATA_W{bus_en}};
    assign ctl_bus_ack = usr_bus_ack & bus_en;

    // R1: no drive toward the user region without a good core supply.
    p_clamp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !core_good |-> (usr_out == '0 && !usr_oe));
    // R2: no logic-analyzer bit passes where its enable is clear.
    p_la_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((la_to_ctl & ~la_en) == '0));
    // R4: a disabled interrupt line never reaches the controlling side.
    p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_to_ctl & ~irq_en) == '0));
    // R5: with the bus enable clear, no data and no acknowledge pass.
    p_bus_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (ctl_bus_dat == '0 && !ctl_bus_ack));
endmodule

// File: rtl/pwr_iso_gate.sv
// Top level of the supply-aware isolation gate: synchronizer, register bank
// and gating fabric. Assumes pg_raw are asynchronous supply-detector levels.
module pwr_iso_gate
    import pwr_iso_pkg::*;
#(
    parameter int LA_W  = 128,
    parameter int OUT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [PG_W-1:0]   pg_raw,
    input  logic [OUT_W-1:0]  ctl_out,
    output logic [OUT_W-1:0]  usr_out,
    output logic              usr_oe,
    input  logic [LA_W-1:0]   la_from_usr,
    output logic [LA_W-1:0]   la_to_ctl,
    input  logic [IRQ_W-1:0]  irq_from_usr,
    output logic [IRQ_W-1:0]  irq_to_ctl,
    input  logic [DATA_W-1:0] usr_bus_dat,
    input  logic              usr_bus_ack,
    output logic [DATA_W-1:0] ctl_bus_dat,
    output logic              ctl_bus_ack
);
    logic [PG_W-1:0]  pg_sync;
    logic [LA_W-1:0]  la_en;
    logic [IRQ_W-1:0] irq_en;
    logic             bus_en;

    // Purpose: the port never stalls; every valid cycle is one access.
    assign req_ready = 1'b1;

    pwr_iso_sync #(.W(PG_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pg_raw),
        .q_sync  (pg_sync)
    );

    pwr_iso_regs #(.LA_W(LA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .pg_sync   (pg_sync),
        .la_en     (la_en),
        .irq_en    (irq_en),
        .bus_en    (bus_en)
    );

    pwr_iso_mask #(.LA_W(LA_W), .OUT_W(OUT_W)) u_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_good    (pg_raw[PG_CORE_USR1]),
        .ctl_out      (ctl_out),
        .usr_out      (usr_out),
        .usr_oe       (usr_oe),
        .la_en        (la_en),
        .la_from_usr  (la_from_usr),
        .la_to_ctl    (la_to_ctl),
        .irq_en       (irq_en),
        .irq_from_usr (irq_from_usr),
        .irq_to_ctl   (irq_to_ctl),
        .bus_en       (bus_en),
        .usr_bus_dat  (usr_bus_dat),
        .usr_bus_ack  (usr_bus_ack),
        .ctl_bus_dat  (ctl_bus_dat),
        .ctl_bus_ack  (ctl_bus_ack)
    );
endmodule

// File: tb/test_pwr_iso_gate.sv
// Directed bench for pwr_iso_gate: one task per scenario, each self-checking.
module test_pwr_iso_gate;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_ready, req_write;
    logic [7:0]   req_addr;
    logic [31:0]  req_wdata;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic [3:0]   pg_raw;
    logic [31:0]  ctl_out, usr_out;
    logic         usr_oe;
    logic [127:0] la_from_usr, la_to_ctl;
    logic [2:0]   irq_from_usr, irq_to_ctl;
    logic [31:0]  usr_bus_dat, ctl_bus_dat;
    logic         usr_bus_ack, ctl_bus_ack;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pwr_iso_gate i_pwr_iso_gate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pg_raw(pg_raw), .ctl_out(ctl_out), .usr_out(usr_out), .usr_oe(usr_oe),
        .la_from_usr(la_from_usr), .la_to_ctl(la_to_ctl),
        .irq_from_usr(irq_from_usr), .irq_to_ctl(irq_to_ctl),
        .usr_bus_dat(usr_bus_dat), .usr_bus_ack(usr_bus_ack),
        .ctl_bus_dat(ctl_bus_dat), .ctl_bus_ack(ctl_bus_ack)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Single write; checks the one-cycle response (R10).
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R10 write rsp_valid", 128'(rsp_valid), 128'(1));
        check("R10 write rsp_rdata", 128'(rsp_rdata), 128'(0));
    endtask

    // Single read; checks response timing (R10) and returns the data.
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 read rsp_valid", 128'(rsp_valid), 128'(1));
        d = rsp_rdata;
        @(negedge clk);
        check("R10 rsp_valid drops", 128'(rsp_valid), 128'(0));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        la_from_usr = '1; irq_from_usr = '1; usr_bus_dat = '1; usr_bus_ack = 1'b1;
        @(negedge clk);
        check("R8 la masked", la_to_ctl, 128'(0));
        check("R8 irq masked", 128'(irq_to_ctl), 128'(0));
        check("R8 bus dat masked", 128'(ctl_bus_dat), 128'(0));
        check("R8 bus ack masked", 128'(ctl_bus_ack), 128'(0));
        check("R10 ready", 128'(req_ready), 128'(1));
        check("R10 idle rsp", 128'(rsp_valid), 128'(0));
        for (int k = 0; k < 4; k++) begin
            bus_read(8'h20 + 8'(4*k), d);
            check("R8 la word reset", 128'(d), 128'(0));
        end
        bus_read(8'h04, d); check("R8 irq en reset", 128'(d), 128'(0));
        bus_read(8'h08, d); check("R8 bus en reset", 128'(d), 128'(0));
    endtask

    task automatic t_clamp();
        ctl_out = 32'hA5C3_0FF1;
        pg_raw = 4'b0000; @(negedge clk);
        check("R1 clamp off", 128'(usr_out), 128'(0));
        check("R1 oe off", 128'(usr_oe), 128'(0));
        pg_raw = 4'b0111; @(negedge clk);
        check("R1 other flags no effect", 128'(usr_out), 128'(0));
        check("R1 oe other flags", 128'(usr_oe), 128'(0));
        pg_raw = 4'b1000; @(negedge clk);
        check("R1 pass", 128'(usr_out), 128'(32'hA5C3_0FF1));
        check("R1 oe on", 128'(usr_oe), 128'(1));
        ctl_out = 32'h1234_5678; @(negedge clk);
        check("R1 pass second pattern", 128'(usr_out), 128'(32'h1234_5678));
    endtask

    task automatic t_la();
        logic [31:0]  d;
        logic [31:0]  w [4];
        logic [127:0] en;
        w[0] = 32'hFFFF_0000; w[1] = 32'h0F0F_0F0F; w[2] = 32'h0000_0000; w[3] = 32'h8000_0001;
        en = {w[3], w[2], w[1], w[0]};
        la_from_usr = '1;
        // Enable change and live data meet in the same cycle.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h20; req_wdata = w[0];
        check("R2 before enable edge", la_to_ctl, 128'(0));
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R2 right after enable edge", la_to_ctl, 128'(w[0]));
        for (int k = 1; k < 4; k++) bus_write(8'h20 + 8'(4*k), w[k]);
        check("R3 word placement all ones", la_to_ctl, en);
        la_from_usr = {4{32'h5555_AAAA}}; @(negedge clk);
        check("R2 pattern mask", la_to_ctl, en & {4{32'h5555_AAAA}});
        for (int k = 0; k < 4; k++) begin
            bus_read(8'h20 + 8'(4*k), d);
            check("R3 la word readback", 128'(d), 128'(w[k]));
        end
    endtask

    task automatic t_irq();
        logic [31:0] d;
        irq_from_usr = 3'b111;
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, d);
        check("R4 irq en upper bits zero", 128'(d), 128'(7));
        check("R4 all enabled", 128'(irq_to_ctl), 128'(3'b111));
        bus_write(8'h04, 32'h0000_0005);
        check("R4 partial enable", 128'(irq_to_ctl), 128'(3'b101));
        irq_from_usr = 3'b010; @(negedge clk);
        check("R4 disabled line blocked", 128'(irq_to_ctl), 128'(0));
    endtask

    task automatic t_bus();
        logic [31:0] d;
        usr_bus_dat = 32'hDEAD_BEEF; usr_bus_ack = 1'b1; @(negedge clk);
        check("R5 dat blocked", 128'(ctl_bus_dat), 128'(0));
        check("R5 ack blocked", 128'(ctl_bus_ack), 128'(0));
        bus_write(8'h08, 32'h0000_0001);
        check("R5 dat pass", 128'(ctl_bus_dat), 128'(32'hDEAD_BEEF));
        check("R5 ack pass", 128'(ctl_bus_ack), 128'(1));
        bus_write(8'h08, 32'hFFFF_FFFE);
        check("R5 bit0 clear blocks dat", 128'(ctl_bus_dat), 128'(0));
        bus_read(8'h08, d);
        check("R5 bus en readback", 128'(d), 128'(0));
        bus_write(8'h08, 32'h0000_0001);
    endtask

    task automatic t_status();
        logic [31:0] d;
        pg_raw = 4'b1010;
        repeat (3) @(negedge clk);
        bus_read(8'h00, d);
        check("R6 status layout", 128'(d), 128'(4'b1010));
        pg_raw = 4'b0101;
        bus_write(8'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_read(8'h00, d);
        check("R6 status follows inputs", 128'(d), 128'(4'b0101));
        bus_read(8'h04, d);
        check("R7 status write left irq en", 128'(d), 128'(5));
        bus_read(8'h20, d);
        check("R7 status write left la word", 128'(d), 128'(32'hFFFF_0000));
        pg_raw = 4'b1000;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_read(8'h0C, d); check("R9 read 0x0C", 128'(d), 128'(0));
        bus_read(8'h30, d); check("R9 read 0x30", 128'(d), 128'(0));
        bus_read(8'h21, d); check("R9 misaligned read", 128'(d), 128'(0));
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_write(8'h22, 32'h0000_0000);
        bus_write(8'h05, 32'h0000_0000);
        bus_read(8'h20, d); check("R9 la word kept", 128'(d), 128'(32'hFFFF_0000));
        bus_read(8'h04, d); check("R9 irq en kept", 128'(d), 128'(5));
        la_from_usr = '1; @(negedge clk);
        check("R9 la outputs kept", la_to_ctl, {32'h8000_0001, 32'h0, 32'h0F0F_0F0F, 32'hFFFF_0000});
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h24;
        @(negedge clk);
        check("R10 b2b first valid", 128'(rsp_valid), 128'(1));
        check("R10 b2b first data", 128'(rsp_rdata), 128'(32'h0F0F_0F0F));
        req_addr = 8'h2C;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 b2b second valid", 128'(rsp_valid), 128'(1));
        check("R10 b2b second data", 128'(rsp_rdata), 128'(32'h8000_0001));
        @(negedge clk);
        check("R10 b2b idle", 128'(rsp_valid), 128'(0));
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        pg_raw = 4'b0000; ctl_out = '0; la_from_usr = '0; irq_from_usr = '0;
        usr_bus_dat = '0; usr_bus_ack = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clamp();
        t_la();
        t_irq();
        t_bus();
        t_status();
        t_unmapped();
        t_back_to_back();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule